// File: doc/BRIEF.md
# Endpoint FIFO Region Address Mapper

This block turns a buffer byte offset for one of five data endpoints into a physical address inside a single shared 1 KB packet memory. Each endpoint owns a fixed region, and the regions are placed back to back in endpoint order. The region size doubles from one endpoint to the next. Within a region, transmit (IN) data fills from the top byte downward and receive (OUT) data fills from the bottom byte upward. When a direction is double-buffered, its second buffer starts at the region midpoint. The second OUT buffer grows upward from the midpoint and the second IN buffer grows downward from just below it.

Configuration arrives as steady fields for each endpoint: an IN maximum packet size, an OUT maximum packet size, and a double-buffer enable for each direction. The block checks each endpoint's configuration against the capacity of its region and flags the ones that do not fit. For every double-buffered direction it keeps a ping-pong bit that flips when a packet is committed. A request gives an endpoint number, a direction, a buffer index and a byte offset. One cycle later the response returns either a valid address or exactly one error class.

Top module: `epm_fifo_mapper`

## Requirements
- R1: Endpoint k (1..5) owns a region of 32·2^(k-1) bytes. The region starts at byte 32·(2^(k-1)−1): endpoint 1 at 0, 2 at 32, 3 at 96, 4 at 224 and 5 at 480.
- R2: An accepted OUT request (`req_dir`=0) on buffer 0 returns the address base + offset.
- R3: An accepted IN request (`req_dir`=1) on buffer 0 returns the address base + size − 1 − offset.
- R4: On buffer 1 of a double-buffered direction, OUT returns base + size/2 + offset and IN returns base + size/2 − 1 − offset.
- R5: `cfg_err_vec[k-1]` is high when the IN maximum plus the OUT maximum of endpoint k exceeds its region size. If either double-buffer enable of that endpoint is set, the limit is half the region size instead. Every request to a flagged endpoint answers with `rsp_cfg_err` and no address.
- R6: Each double-buffered direction selects its buffer from a ping-pong bit and ignores `req_buf`. The bit is 0 after reset. It toggles on each `commit_valid` cycle that names that endpoint and direction. It is held at 0 while that direction's double-buffer enable is low. A request in the same cycle as a commit uses the value from before the commit.
- R7: A request on a single-buffered direction with `req_buf`=1 answers with `rsp_rng_err`.
- R8: A request whose offset is greater than or equal to the configured maximum for its direction answers with `rsp_rng_err`. A maximum of 0 therefore rejects every request in that direction, which covers IN-only, OUT-only and unused endpoints.
- R9: A request with endpoint number 0, or a number above 5, answers with `rsp_ep_err`.
- R10: The response register is updated at the clock edge on which a request is sampled; a response is never produced combinationally. With `rsp_valid` high, exactly one of `rsp_ok`, `rsp_ep_err`, `rsp_cfg_err` and `rsp_rng_err` is set. The priority order is endpoint error, then configuration error, then range error. `rsp_addr` is 0 unless `rsp_ok` is set. Without a request, all response outputs are 0.
- R11: Reset is synchronous and active-low. It clears all response outputs and all ping-pong bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_in_max | input | 50 | IN maximum size per endpoint, 10 bits each, endpoint 1 in the low bits |
| cfg_out_max | input | 50 | OUT maximum size per endpoint, 10 bits each, endpoint 1 in the low bits |
| cfg_in_dbl | input | 5 | IN double-buffer enable, bit k-1 for endpoint k |
| cfg_out_dbl | input | 5 | OUT double-buffer enable, bit k-1 for endpoint k |
| req_valid | input | 1 | Request strobe |
| req_ep | input | 3 | Requested endpoint number |
| req_dir | input | 1 | Direction: 1 = IN, 0 = OUT |
| req_buf | input | 1 | Buffer index for single-buffered use |
| req_off | input | 10 | Byte offset within the packet |
| commit_valid | input | 1 | Packet commit strobe |
| commit_ep | input | 3 | Endpoint number of the commit |
| commit_dir | input | 1 | Direction of the commit: 1 = IN, 0 = OUT |
| cfg_err_vec | output | 5 | Configuration error flag per endpoint |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Address is valid |
| rsp_addr | output | 10 | Physical memory address |
| rsp_ep_err | output | 1 | Endpoint number out of range |
| rsp_cfg_err | output | 1 | Requested endpoint is misconfigured |
| rsp_rng_err | output | 1 | Offset or buffer index out of range |

## Verification
The bench builds the mapper with its default parameters: five endpoints, a 32-byte first region and a 10-bit address. With these values the top region spans bytes 480 to 991, so IN addressing from the top of that region exercises the upper end of the 1 KB space. Because each region size is a power of two from 32 to 512, every size takes the half-region path for the second buffers. Limits of 16 through 256 bytes can be probed at exactly the boundary, at one byte below it and at one byte above it.

// File: rtl/epm_pkg.sv
// Package: shared direction encoding, response flag bundle and region
// geometry helpers for the endpoint FIFO region mapper.
// Assumes region sizes double per endpoint starting from a base size.
package epm_pkg;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } epm_dir_e;

    typedef struct packed {
        logic ok;
        logic ep_err;
        logic cfg_err;
        logic rng_err;
    } epm_flags_t;

    // Size in bytes of the region owned by zero-based endpoint slot idx.
    function automatic int unsigned region_size(int unsigned base, int unsigned idx);
        return base << idx;
    endfunction

    // First byte of the region for zero-based slot idx (regions are contiguous).
    function automatic int unsigned region_base(int unsigned base, int unsigned idx);
        return base * ((32'd1 << idx) - 32'd1);
    endfunction

endpackage

// File: rtl/epm_region_check.sv
// Module: checks each endpoint's IN + OUT maximum against its region capacity.
// The capacity is the full region when single-buffered and half of it when
// either direction is double-buffered. Purely combinational; assumes the
// configuration is held steady by its owner.
module epm_region_check #(
    parameter int NUM_EP     = 5,
    parameter int BASE_BYTES = 32,
    parameter int SZ_W       = 10
) (
    input  logic [NUM_EP*SZ_W-1:0] cfg_in_max,
    input  logic [NUM_EP*SZ_W-1:0] cfg_out_max,
    input  logic [NUM_EP-1:0]      cfg_in_dbl,
    input  logic [NUM_EP-1:0]      cfg_out_dbl,
    output logic [NUM_EP-1:0]      cfg_err_vec
);

    localparam int SUM_W = SZ_W + 1;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        localparam int unsigned RSZ = epm_pkg::region_size(BASE_BYTES, g);

        logic [SUM_W-1:0] need;
        logic [SUM_W-1:0] room;

        // Total bytes requested by both directions of this endpoint.
        assign need = {1'b0, cfg_in_max[g*SZ_W +: SZ_W]} + {1'b0, cfg_out_max[g*SZ_W +: SZ_W]};
        // Capacity available under the chosen buffering scheme.
        assign room = (cfg_in_dbl[g] || cfg_out_dbl[g]) ? SUM_W'(RSZ / 2) : SUM_W'(RSZ);
        // Flag the endpoint when the request does not fit.
        assign cfg_err_vec[g] = (need > room);
    end

endmodule

// File: rtl/epm_pingpong.sv
// Module: keeps one ping-pong buffer-select bit per endpoint and direction.
// A bit toggles on a commit naming its endpoint and direction. It is held at
// zero while its double-buffer enable is low. Assumes endpoint numbers are
// 1-based on the commit port.
module epm_pingpong #(
    parameter int NUM_EP = 5,
    parameter int EP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] cfg_in_dbl,
    input  logic [NUM_EP-1:0] cfg_out_dbl,
    input  logic              commit_valid,
    input  logic [EP_W-1:0]   commit_ep,
    input  logic              commit_dir,
    output logic [NUM_EP-1:0] ping_in,
    output logic [NUM_EP-1:0] ping_out
);

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        logic hit;

        // Commit strobe addressed to this endpoint slot.
        assign hit = commit_valid && (commit_ep == EP_W'(g + 1));

        // IN-direction select bit: clear, hold or toggle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ping_in[g] <= 1'b0;
            end else if (!cfg_in_dbl[g]) begin
                ping_in[g] <= 1'b0;
            end else if (hit && (commit_dir == epm_pkg::DIR_IN)) begin
                ping_in[g] <= ~ping_in[g];
            end
        end

        // OUT-direction select bit: clear, hold or toggle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ping_out[g] <= 1'b0;
            end else if (!cfg_out_dbl[g]) begin
                ping_out[g] <= 1'b0;
            end else if (hit && (commit_dir == epm_pkg::DIR_OUT)) begin
                ping_out[g] <= ~ping_out[g];
            end
        end
    end

endmodule

// File: rtl/epm_addr_gen.sv
// Module: combinational address generator. It selects the requested
// endpoint's geometry and configuration, classifies the request and
// computes the physical address. OUT grows upward from the region bottom (or
// midpoint); IN grows downward from the region top (or just below the
// midpoint). Assumes a valid configuration has been checked by the region
// check stage.
module epm_addr_gen #(
    parameter int NUM_EP     = 5,
    parameter int BASE_BYTES = 32,
    parameter int ADDR_W     = 10,
    parameter int SZ_W       = 10,
    parameter int EP_W       = 3
) (
    input  logic [NUM_EP*SZ_W-1:0] cfg_in_max,
    input  logic [NUM_EP*SZ_W-1:0] cfg_out_max,
    input  logic [NUM_EP-1:0]      cfg_in_dbl,
    input  logic [NUM_EP-1:0]      cfg_out_dbl,
    input  logic [NUM_EP-1:0]      cfg_err_vec,
    input  logic [NUM_EP-1:0]      ping_in,
    input  logic [NUM_EP-1:0]      ping_out,
    input  logic [EP_W-1:0]        req_ep,
    input  logic                   req_dir,
    input  logic                   req_buf,
    input  logic [SZ_W-1:0]        req_off,
    output epm_pkg::epm_flags_t    flags,
    output logic [ADDR_W-1:0]      addr
);

    logic              ep_hit;
    logic [ADDR_W-1:0] sel_size;
    logic [ADDR_W-1:0] sel_base;
    logic [SZ_W-1:0]   sel_max;
    logic              sel_dbl;
    logic              sel_ping;
    logic              sel_bad;
    logic              use_hi;
    logic              buf_bad;
    logic              off_bad;
    logic [ADDR_W-1:0] off_a;
    logic [ADDR_W-1:0] half;
    logic [ADDR_W-1:0] local_off;

    // Pick the geometry and configuration of the addressed endpoint.
    always_comb begin
        ep_hit   = 1'b0;
        sel_size = '0;
        sel_base = '0;
        sel_max  = '0;
        sel_dbl  = 1'b0;
        sel_ping = 1'b0;
        sel_bad  = 1'b0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (req_ep == EP_W'(i + 1)) begin
                ep_hit   = 1'b1;
                sel_size = ADDR_W'(epm_pkg::region_size(BASE_BYTES, i));
                sel_base = ADDR_W'(epm_pkg::region_base(BASE_BYTES, i));
                sel_bad  = cfg_err_vec[i];
                if (req_dir == epm_pkg::DIR_IN) begin
                    sel_max  = cfg_in_max[i*SZ_W +: SZ_W];
                    sel_dbl  = cfg_in_dbl[i];
                    sel_ping = ping_in[i];
                end else begin
                    sel_max  = cfg_out_max[i*SZ_W +: SZ_W];
                    sel_dbl  = cfg_out_dbl[i];
                    sel_ping = ping_out[i];
                end
            end
        end
    end

    // Resolve which buffer is used and whether the request is in range.
    always_comb begin
        use_hi  = sel_dbl ? sel_ping : 1'b0;
        buf_bad = !sel_dbl && req_buf;
        off_bad = (req_off >= sel_max);
    end

    // Compute the offset inside the region for the chosen buffer and direction.
    always_comb begin
        off_a = ADDR_W'(req_off);
        half  = sel_size >> 1;
        if (req_dir == epm_pkg::DIR_IN) begin
            local_off = (use_hi ? half : sel_size) - ADDR_W'(1) - off_a;
        end else begin
            local_off = (use_hi ? half : '0) + off_a;
        end
    end

    // Classify the request with priority endpoint > config > range.
    always_comb begin
        flags.ep_err  = !ep_hit;
        flags.cfg_err = ep_hit && sel_bad;
        flags.rng_err = ep_hit && !sel_bad && (buf_bad || off_bad);
        flags.ok      = ep_hit && !sel_bad && !buf_bad && !off_bad;
        addr          = flags.ok ? (sel_base + local_off) : '0;
    end

endmodule

// File: rtl/epm_fifo_mapper.sv
// Module: top of the endpoint FIFO region mapper. It ties together the
// configuration check, the ping-pong state and the address generator, and
// registers the response one cycle after the request. Assumes configuration
// inputs change only between packets.
module epm_fifo_mapper #(
    parameter int NUM_EP     = 5,
    parameter int BASE_BYTES = 32,
    parameter int ADDR_W     = 10,
    localparam int SZ_W      = $clog2(BASE_BYTES << (NUM_EP - 1)) + 1,
    localparam int EP_W      = $clog2(NUM_EP + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_EP*SZ_W-1:0] cfg_in_max,
    input  logic [NUM_EP*SZ_W-1:0] cfg_out_max,
    input  logic [NUM_EP-1:0]      cfg_in_dbl,
    input  logic [NUM_EP-1:0]      cfg_out_dbl,
    input  logic                   req_valid,
    input  logic [EP_W-1:0]        req_ep,
    input  logic                   req_dir,
    input  logic                   req_buf,
    input  logic [SZ_W-1:0]        req_off,
    input  logic                   commit_valid,
    input  logic [EP_W-1:0]        commit_ep,
    input  logic                   commit_dir,
    output logic [NUM_EP-1:0]      cfg_err_vec,
    output logic                   rsp_valid,
    output logic                   rsp_ok,
    output logic [ADDR_W-1:0]      rsp_addr,
    output logic                   rsp_ep_err,
    output logic                   rsp_cfg_err,
    output logic                   rsp_rng_err
);

    logic [NUM_EP-1:0]   ping_in;
    logic [NUM_EP-1:0]   ping_out;
    epm_pkg::epm_flags_t nxt_flags;
    logic [ADDR_W-1:0]   nxt_addr;

    epm_region_check #(
        .NUM_EP     (NUM_EP),
        .BASE_BYTES (BASE_BYTES),
        .SZ_W       (SZ_W)
    ) u_check (
        .cfg_in_max  (cfg_in_max),
        .cfg_out_max (cfg_out_max),
        .cfg_in_dbl  (cfg_in_dbl),
        .cfg_out_dbl (cfg_out_dbl),
        .cfg_err_vec (cfg_err_vec)
    );

    epm_pingpong #(
        .NUM_EP (NUM_EP),
        .EP_W   (EP_W)
    ) u_ping (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_in_dbl   (cfg_in_dbl),
        .cfg_out_dbl  (cfg_out_dbl),
        .commit_valid (commit_valid),
        .commit_ep    (commit_ep),
        .commit_dir   (commit_dir),
        .ping_in      (ping_in),
        .ping_out     (ping_out)
    );

    epm_addr_gen #(
        .NUM_EP     (NUM_EP),
        .BASE_BYTES (BASE_BYTES),
        .ADDR_W     (ADDR_W),
        .SZ_W       (SZ_W),
        .EP_W       (EP_W)
    ) u_gen (
        .cfg_in_max  (cfg_in_max),
        .cfg_out_max (cfg_out_max),
        .cfg_in_dbl  (cfg_in_dbl),
        .cfg_out_dbl (cfg_out_dbl),
        .cfg_err_vec (cfg_err_vec),
        .ping_in     (ping_in),
        .ping_out    (ping_out),
        .req_ep      (req_ep),
        .req_dir     (req_dir),
        .req_buf     (req_buf),
        .req_off     (req_off),
        .flags       (nxt_flags),
        .addr        (nxt_addr)
    );

    // Register the response one cycle after the request; quiet when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_ok      <= 1'b0;
            rsp_addr    <= '0;
            rsp_ep_err  <= 1'b0;
            rsp_cfg_err <= 1'b0;
            rsp_rng_err <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_ok      <= req_valid && nxt_flags.ok;
            rsp_addr    <= req_valid ? nxt_addr : '0;
            rsp_ep_err  <= req_valid && nxt_flags.ep_err;
            rsp_cfg_err <= req_valid && nxt_flags.cfg_err;
            rsp_rng_err <= req_valid && nxt_flags.rng_err;
        end
    end

endmodule

// File: rtl/epm_fifo_mapper_chk.sv
// Checker: temporal properties of the mapper's response port, attached to
// the top module by the bind statement at the end of this file.
module epm_fifo_mapper_chk #(
    parameter int NUM_EP     = 5,
    parameter int BASE_BYTES = 32,
    parameter int ADDR_W     = 10,
    parameter int EP_W       = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [EP_W-1:0]   req_ep,
    input logic [NUM_EP-1:0] cfg_err_vec,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_ep_err,
    input logic              rsp_cfg_err,
    input logic              rsp_rng_err
);

    localparam int unsigned TOTAL = epm_pkg::region_base(BASE_BYTES, NUM_EP);

    logic ep_in;
    logic cfg_hit;

    // Request names an existing endpoint.
    assign ep_in   = (req_ep != '0) && (req_ep <= EP_W'(NUM_EP));
    // Requested endpoint is currently flagged as misconfigured.
    assign cfg_hit = ep_in && |(cfg_err_vec & (NUM_EP'(1) << (req_ep - EP_W'(1))));

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_ok, rsp_ep_err, rsp_cfg_err, rsp_rng_err}) == 1)); // R10
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ({rsp_ok, rsp_ep_err, rsp_cfg_err, rsp_rng_err} == 4'b0 && rsp_addr == '0)); // R10
    AST_NO_ADDR_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (rsp_addr == '0)); // R10
    AST_ADDR_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> (32'(rsp_addr) < TOTAL)); // R1
    AST_BAD_EP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ep_in) |=> rsp_ep_err); // R9
    AST_CFG_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_hit) |=> (rsp_cfg_err && !rsp_ok)); // R5

endmodule

bind epm_fifo_mapper epm_fifo_mapper_chk #(
    .NUM_EP     (NUM_EP),
    .BASE_BYTES (BASE_BYTES),
    .ADDR_W     (ADDR_W),
    .EP_W       (EP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ep      (req_ep),
    .cfg_err_vec (cfg_err_vec),
    .rsp_valid   (rsp_valid),
    .rsp_ok      (rsp_ok),
    .rsp_addr    (rsp_addr),
    .rsp_ep_err  (rsp_ep_err),
    .rsp_cfg_err (rsp_cfg_err),
    .rsp_rng_err (rsp_rng_err)
);

// File: tb/epm_fifo_mapper_tb.sv
// Bench: a behavioural reference model, compared with the mapper every clock.
module epm_fifo_mapper_tb;

    localparam int NEP = 5;
    localparam int SW  = 10;
    localparam int EW  = 3;
    localparam int AW  = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NEP*SW-1:0] cfg_in_max, cfg_out_max;
    logic [NEP-1:0]  cfg_in_dbl, cfg_out_dbl;
    logic            req_valid, req_dir, req_buf, commit_valid, commit_dir;
    logic [EW-1:0]   req_ep, commit_ep;
    logic [SW-1:0]   req_off;
    logic [NEP-1:0]  cfg_err_vec;
    logic            rsp_valid, rsp_ok, rsp_ep_err, rsp_cfg_err, rsp_rng_err;
    logic [AW-1:0]   rsp_addr;

    int m_in [1:5];
    int m_out[1:5];
    bit m_idb[1:5];
    bit m_odb[1:5];
    bit p_in [1:5];
    bit p_out[1:5];

    bit    e_valid, e_ok, e_ep, e_cfg, e_rng;
    int    e_addr;
    string e_tag = "R11";
    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    started = 0;
    bit    done    = 0;

    always #4 clk = ~clk;

    epm_fifo_mapper u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_in_max(cfg_in_max), .cfg_out_max(cfg_out_max),
        .cfg_in_dbl(cfg_in_dbl), .cfg_out_dbl(cfg_out_dbl),
        .req_valid(req_valid), .req_ep(req_ep), .req_dir(req_dir),
        .req_buf(req_buf), .req_off(req_off),
        .commit_valid(commit_valid), .commit_ep(commit_ep), .commit_dir(commit_dir),
        .cfg_err_vec(cfg_err_vec),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_addr(rsp_addr),
        .rsp_ep_err(rsp_ep_err), .rsp_cfg_err(rsp_cfg_err), .rsp_rng_err(rsp_rng_err)
    );

    always_comb begin
        for (int e = 0; e < NEP; e++) begin
            cfg_in_max[e*SW +: SW]  = SW'(m_in[e+1]);
            cfg_out_max[e*SW +: SW] = SW'(m_out[e+1]);
            cfg_in_dbl[e]           = m_idb[e+1];
            cfg_out_dbl[e]          = m_odb[e+1];
        end
    end

    function automatic bit cfg_bad(int ep);
        int sz = 32 << (ep - 1);
        int lim = (m_idb[ep] || m_odb[ep]) ? sz / 2 : sz;
        return (m_in[ep] + m_out[ep]) > lim;
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Reference model: expected response and ping-pong state per clock.
    always @(posedge clk) begin
        int sz, bs, mx, loc, ep;
        bit dbl, hi;
        started = 1;
        cyc++;
        if (!rst_n) begin
            e_valid = 0; e_ok = 0; e_ep = 0; e_cfg = 0; e_rng = 0; e_addr = 0; e_tag = "R11";
            for (int e = 1; e <= 5; e++) begin p_in[e] = 0; p_out[e] = 0; end
        end else begin
            e_valid = req_valid; e_ok = 0; e_ep = 0; e_cfg = 0; e_rng = 0; e_addr = 0; e_tag = "R10";
            if (req_valid) begin
                ep = int'(req_ep);
                if (ep < 1 || ep > 5) begin
                    e_ep = 1; e_tag = "R9";
                end else if (cfg_bad(ep)) begin
                    e_cfg = 1; e_tag = "R5";
                end else begin
                    sz = 32 << (ep - 1);
                    bs = 0;
                    for (int k = 1; k < ep; k++) bs += 32 << (k - 1);
                    dbl = req_dir ? m_idb[ep] : m_odb[ep];
                    mx  = req_dir ? m_in[ep] : m_out[ep];
                    if (!dbl && req_buf) begin
                        e_rng = 1; e_tag = "R7";
                    end else if (int'(req_off) >= mx) begin
                        e_rng = 1; e_tag = "R8";
                    end else begin
                        hi = dbl ? (req_dir ? p_in[ep] : p_out[ep]) : 1'b0;
                        if (req_dir) loc = (hi ? sz / 2 : sz) - 1 - int'(req_off);
                        else         loc = (hi ? sz / 2 : 0) + int'(req_off);
                        e_ok = 1; e_addr = bs + loc;
                        e_tag = hi ? "R4" : (dbl ? "R6" : (req_dir ? "R3" : "R2"));
                    end
                end
            end
            for (int e = 1; e <= 5; e++) begin
                if (!m_idb[e]) p_in[e] = 0;
                else if (commit_valid && int'(commit_ep) == e && commit_dir) p_in[e] = !p_in[e];
                if (!m_odb[e]) p_out[e] = 0;
                else if (commit_valid && int'(commit_ep) == e && !commit_dir) p_out[e] = !p_out[e];
            end
        end
        if (cyc > 200000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        int act, exp, ev;
        if (started && !done) begin
            act = {rsp_valid, rsp_ok, rsp_ep_err, rsp_cfg_err, rsp_rng_err, rsp_addr};
            exp = {e_valid, e_ok, e_ep, e_cfg, e_rng, AW'(e_addr)};
            chk(e_tag, act, exp, "response");
            ev = 0;
            for (int e = 1; e <= 5; e++) if (cfg_bad(e)) ev |= 1 << (e - 1);
            chk("R5", int'(cfg_err_vec), ev, "cfg_err_vec");
        end
    end

    task automatic idle();
        req_valid = 0; req_ep = 0; req_dir = 0; req_buf = 0; req_off = 0;
        commit_valid = 0; commit_ep = 0; commit_dir = 0;
    endtask

    task automatic send(int ep, int dir, int b, int off, bit cv = 0, int cep = 0, int cdir = 0);
        req_valid = 1; req_ep = EW'(ep); req_dir = dir[0]; req_buf = b[0]; req_off = SW'(off);
        commit_valid = cv; commit_ep = EW'(cep); commit_dir = cdir[0];
        @(negedge clk);
    endtask

    task automatic commit(int ep, int dir);
        idle();
        commit_valid = 1; commit_ep = EW'(ep); commit_dir = dir[0];
        @(negedge clk);
        idle();
    endtask

    task automatic setcfg(int ep, int i, int o, bit idb, bit odb);
        m_in[ep] = i; m_out[ep] = o; m_idb[ep] = idb; m_odb[ep] = odb;
    endtask

    initial begin
        rst_n = 0;
        for (int e = 1; e <= 5; e++) setcfg(e, 0, 0, 0, 0);
        idle();
        repeat (3) @(negedge clk);
        chk("R11", int'({rsp_valid, rsp_ok, rsp_ep_err, rsp_cfg_err, rsp_rng_err, rsp_addr}), 0, "reset outputs");
        rst_n = 1;
        @(negedge clk);

        // R1: region bases laid out contiguously.
        for (int e = 1; e <= 5; e++) setcfg(e, 0, 1, 0, 0);
        for (int k = 1; k <= 5; k++) begin
            send(k, 0, 0, 0);
            chk("R1", int'(rsp_addr), 32 * ((1 << (k - 1)) - 1), "region base");
        end

        setcfg(1, 16, 16, 0, 0);
        setcfg(2, 20, 40, 0, 0);
        setcfg(3, 32, 32, 1, 1);
        setcfg(4, 64, 0, 1, 0);
        setcfg(5, 0, 0, 0, 0);
        idle(); @(negedge clk);

        // R2 / R3 / R8 boundaries on single-buffered endpoints.
        send(1, 0, 0, 0);   chk("R2", int'(rsp_addr), 0, "ep1 OUT off 0");
        send(1, 0, 0, 15);  chk("R2", int'(rsp_addr), 15, "ep1 OUT off 15");
        send(1, 0, 0, 16);  chk("R8", int'(rsp_rng_err), 1, "ep1 OUT off 16");
        send(1, 1, 0, 0);   chk("R3", int'(rsp_addr), 31, "ep1 IN off 0");
        send(1, 1, 0, 15);  chk("R3", int'(rsp_addr), 16, "ep1 IN off 15");
        send(2, 1, 0, 19);  chk("R3", int'(rsp_addr), 32 + 63 - 19, "ep2 IN off 19");
        send(2, 1, 0, 20);  chk("R8", int'(rsp_rng_err), 1, "ep2 IN off 20");
        send(1, 0, 1, 0);   chk("R7", int'(rsp_rng_err), 1, "single buffer index 1");
        send(4, 0, 0, 0);   chk("R8", int'(rsp_rng_err), 1, "IN-only OUT request");
        send(5, 1, 0, 0);   chk("R8", int'(rsp_rng_err), 1, "unused endpoint");
        send(0, 0, 0, 0);   chk("R9", int'(rsp_ep_err), 1, "endpoint 0");
        send(6, 1, 0, 0);   chk("R9", int'(rsp_ep_err), 1, "endpoint 6");
        send(7, 0, 0, 0);   chk("R9", int'(rsp_ep_err), 1, "endpoint 7");
        idle(); @(negedge clk);
        chk("R10", int'(rsp_valid), 0, "idle after requests");

        // R6 / R4: ping-pong on ep3, buffer index ignored.
        send(3, 0, 1, 0);   chk("R6", int'(rsp_addr), 96, "ep3 OUT ping 0 ignores buf");
        commit(3, 0);
        send(3, 0, 0, 5);   chk("R4", int'(rsp_addr), 96 + 64 + 5, "ep3 OUT second buffer");
        send(3, 1, 0, 0);   chk("R6", int'(rsp_addr), 96 + 127, "ep3 IN ping untouched");
        send(3, 1, 0, 0, 1, 3, 1); chk("R6", int'(rsp_addr), 96 + 127, "commit same cycle uses old bit");
        send(3, 1, 0, 31);  chk("R4", int'(rsp_addr), 96 + 63 - 31, "ep3 IN second buffer");
        send(4, 1, 0, 0);   chk("R6", int'(rsp_addr), 224 + 255, "ep4 IN ping 0");
        commit(4, 1);
        send(4, 1, 1, 63);  chk("R4", int'(rsp_addr), 224 + 127 - 63, "ep4 IN second buffer");
        m_idb[4] = 0; m_in[4] = 64;
        idle(); @(negedge clk);
        m_idb[4] = 1;
        send(4, 1, 0, 0);   chk("R6", int'(rsp_addr), 224 + 255, "disable clears ping");

        // R5: capacity limits at the boundary.
        setcfg(1, 17, 16, 0, 0);
        setcfg(2, 0, 64, 0, 0);
        setcfg(3, 33, 32, 1, 0);
        idle(); @(negedge clk);
        chk("R5", int'(cfg_err_vec[0]), 1, "ep1 33 > 32");
        chk("R5", int'(cfg_err_vec[1]), 0, "ep2 64 fits");
        chk("R5", int'(cfg_err_vec[2]), 1, "ep3 double 65 > 64");
        send(1, 0, 0, 0);   chk("R5", int'(rsp_cfg_err), 1, "request to bad ep1");
        send(3, 0, 0, 0);   chk("R5", int'(rsp_addr), 0, "no address for bad ep3");
        send(2, 0, 0, 63);  chk("R2", int'(rsp_addr), 32 + 63, "ep2 full OUT");
        setcfg(2, 1, 64, 0, 0);
        setcfg(3, 32, 32, 0, 0);
        idle(); @(negedge clk);
        chk("R5", int'(cfg_err_vec[1]), 1, "ep2 65 > 64");
        chk("R5", int'(cfg_err_vec[2]), 0, "ep3 single 64 fits");

        // Mixed stimulus with periodic reconfiguration.
        for (int r = 0; r < 30; r++) begin
            for (int e = 1; e <= 5; e++) begin
                int sz = 32 << (e - 1);
                setcfg(e, $urandom_range(0, sz / 2 + 4), $urandom_range(0, sz / 2 + 4),
                       1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end
            for (int n = 0; n < 60; n++) begin
                if ($urandom_range(0, 4) == 0) begin
                    idle(); @(negedge clk);
                end else begin
                    send($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 1),
                         $urandom_range(0, 280), 1'($urandom_range(0, 1)),
                         $urandom_range(1, 5), $urandom_range(0, 1));
                end
            end
        end
        idle();
        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule